// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block converts a logical address, made of a 16-bit selector and a 32-bit offset, into a 32-bit linear address. It looks the selector up in one of two descriptor tables held in memory. Each table has a base address and a byte limit supplied by the host. The block reads the 8-byte descriptor through a synchronous read port. It then rebuilds the split base and limit fields, scales the limit by the granularity flag, and returns either the translated address or a fault code.

A request is taken with a valid/ready handshake. The selector checks need nothing from memory: the privilege comparison and the table-bound test. When one of them fails, the block answers one cycle after acceptance and never touches memory. Otherwise it issues exactly one descriptor read and answers three cycles after acceptance. The answer is a one-cycle `done` pulse carrying the linear address and the fault code.

Top module: `seg_xlate`

## Requirements
- R1: Selector bits 15:3 are the table index, bit 2 picks the table (0 = global, 1 = local) and bits 1:0 are the requested privilege. The descriptor is fetched from the selected table's base plus index×8 with exactly one read of the memory port, and its data is taken on the cycle after the read enable.
- R2: The 32-bit segment base is rebuilt from descriptor bits 39:16 (base 23:0) and 63:56 (base 31:24). The linear address is base plus offset, wrapping modulo 2^32.
- R3: The 20-bit limit is rebuilt from descriptor bits 15:0 (limit 15:0) and 51:48 (limit 19:16). When the granularity flag in descriptor bit 55 is 0, the limit is used as a byte limit.
- R4: When descriptor bit 55 is 1, the effective byte limit is (limit<<12)|0xFFF.
- R5: An offset equal to the effective limit translates. An offset above it gives fault code 01 (protection). Code 00 means no fault, code 10 means not present, and code 11 never appears.
- R6: If the current privilege input is numerically greater than the selector's requested privilege, the block answers with fault 01 one cycle after acceptance and issues no memory read.
- R7: If index×8+7 exceeds the selected table's byte limit, the block answers with fault 01 one cycle after acceptance and issues no memory read. An index whose last byte equals the limit is accepted.
- R8: A descriptor with its present flag (bit 47) clear gives fault code 10. This takes priority over the offset limit check.
- R9: `req_ready` is high only while idle and drops the cycle after a request is accepted. Inputs offered while busy are ignored. `done` is a one-cycle pulse, three cycles after acceptance when a descriptor is read. `lin_addr` is zero whenever the fault code is non-zero.
- R10: While reset is high and after it is released: `req_ready` = 1, `done` = 0 and `mem_rd_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_sel | input | 16 | Selector |
| req_off | input | 32 | Offset within the segment |
| cur_pl | input | 2 | Current privilege level |
| gtab_base | input | 32 | Global table byte address |
| gtab_lim | input | 16 | Global table byte limit |
| ltab_base | input | 32 | Local table byte address |
| ltab_lim | input | 16 | Local table byte limit |
| mem_rd_en | output | 1 | Descriptor read strobe |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rdata | input | 64 | Descriptor data, valid the cycle after the strobe |
| done | output | 1 | Result pulse |
| lin_addr | output | 32 | Linear address (zero on fault) |
| fault | output | 2 | 00 none, 01 protection, 10 not present |

## Verification
The assertions watch the handshake shape on every cycle:
- `done` lasts one cycle and only arrives while idle.
- `ready` drops right after acceptance.
- Each read is single, and no answer follows a read within one cycle.
- Faulted answers carry a zero address, and the illegal fault code never appears.

Only the bench scenarios show that the values are right. These cover the reassembled base and limit, granularity scaling at the exact limit edge, the choice between the two tables, the not-present priority and the early privilege and table-bound faults. The bench also checks latency and read counts for each path.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PROT = 2'b01,
    FLT_NP   = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT,
    ST_EVAL
  } state_e;

  localparam int SEL_W     = 16;
  localparam int IDX_LSB   = 3;
  localparam int TI_BIT    = 2;
  localparam int DESC_W    = 64;
  localparam int SEG_LIM_W = 20;
  localparam int GRAN_SH   = 12;
  localparam int GRAN_BIT  = 55;
  localparam int PRES_BIT  = 47;
endpackage

// File: rtl/seg_sel_check.sv
module seg_sel_check
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] gbase,
  input  logic [TLIM_W-1:0] glim,
  input  logic [ADDR_W-1:0] lbase,
  input  logic [TLIM_W-1:0] llim,
  output logic [ADDR_W-1:0] desc_addr,
  output fault_e            chk_fault
);
  localparam int IDX_W = SEL_W - IDX_LSB;
  localparam int OFS_W = IDX_W + 3;
  localparam int CMP_W = ((OFS_W > TLIM_W) ? OFS_W : TLIM_W) + 1;

  logic [IDX_W-1:0]  idx;
  logic              use_local;
  logic [1:0]        rpl;
  logic [ADDR_W-1:0] tbase;
  logic [TLIM_W-1:0] tlim;
  logic [CMP_W-1:0]  last_byte;
  logic [CMP_W-1:0]  lim_ext;

  assign idx       = sel[SEL_W-1:IDX_LSB];
  assign use_local = sel[TI_BIT];
  assign rpl       = sel[1:0];
  assign tbase     = use_local ? lbase : gbase;
  assign tlim      = use_local ? llim  : glim;
  assign last_byte = CMP_W'({idx, 3'b111});
  assign lim_ext   = CMP_W'(tlim);
  assign desc_addr = tbase + ADDR_W'({idx, 3'b000});

  always_comb begin
    if (cpl > rpl || last_byte > lim_ext) chk_fault = FLT_PROT;
    else                                  chk_fault = FLT_NONE;
  end
endmodule

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [ADDR_W-1:0] off,
  output logic [ADDR_W-1:0] lin,
  output fault_e            dec_fault
);
  localparam int EFF_W = SEG_LIM_W + GRAN_SH;

  logic [31:0]          base;
  logic [SEG_LIM_W-1:0] lim20;
  logic [EFF_W-1:0]     eff_lim;
  logic                 gran;
  logic                 present;
  logic                 unused_bits;

  assign base        = {desc[63:56], desc[39:16]};
  assign lim20       = {desc[51:48], desc[15:0]};
  assign gran        = desc[GRAN_BIT];
  assign present     = desc[PRES_BIT];
  assign eff_lim     = gran ? {lim20, {GRAN_SH{1'b1}}} : EFF_W'(lim20);
  assign lin         = ADDR_W'(base) + off;
  assign unused_bits = ^{desc[54:52], desc[46:40]};

  always_comb begin
    if (!present)                              dec_fault = FLT_NP;
    else if (EFF_W'(off) > eff_lim ||
             (ADDR_W > EFF_W && (off >> EFF_W) != '0)) dec_fault = FLT_PROT;
    else                                       dec_fault = FLT_NONE;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [15:0]       req_sel,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [1:0]        cur_pl,
  input  logic [ADDR_W-1:0] gtab_base,
  input  logic [TLIM_W-1:0] gtab_lim,
  input  logic [ADDR_W-1:0] ltab_base,
  input  logic [TLIM_W-1:0] ltab_lim,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [63:0]       mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] lin_addr,
  output logic [1:0]        fault
);
  state_e            state;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] off_q;
  logic [1:0]        cpl_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic [ADDR_W-1:0] lin_q;
  fault_e            fault_q;

  logic [ADDR_W-1:0] desc_addr;
  fault_e            chk_fault;
  logic [ADDR_W-1:0] dec_lin;
  fault_e            dec_fault;

  seg_sel_check #(.ADDR_W(ADDR_W), .TLIM_W(TLIM_W)) u_chk (
    .sel       (sel_q),
    .cpl       (cpl_q),
    .gbase     (gtab_base),
    .glim      (gtab_lim),
    .lbase     (ltab_base),
    .llim      (ltab_lim),
    .desc_addr (desc_addr),
    .chk_fault (chk_fault)
  );

  seg_desc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .desc      (mem_rdata),
    .off       (off_q),
    .lin       (dec_lin),
    .dec_fault (dec_fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sel_q   <= '0;
      off_q   <= '0;
      cpl_q   <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      lin_q   <= '0;
      fault_q <= FLT_NONE;
    end else begin
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            sel_q <= req_sel;
            off_q <= req_off;
            cpl_q <= cur_pl;
            state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (chk_fault != FLT_NONE) begin
            done_q  <= 1'b1;
            fault_q <= chk_fault;
            lin_q   <= '0;
            state   <= ST_IDLE;
          end else begin
            rd_q   <= 1'b1;
            addr_q <= desc_addr;
            state  <= ST_WAIT;
          end
        end
        ST_WAIT: state <= ST_EVAL;
        default: begin
          done_q  <= 1'b1;
          fault_q <= dec_fault;
          lin_q   <= (dec_fault == FLT_NONE) ? dec_lin : '0;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign mem_rd_en = rd_q;
  assign mem_addr  = addr_q;
  assign done      = done_q;
  assign lin_addr  = lin_q;
  assign fault     = fault_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault != 2'b00) |-> lin_addr == '0);

  // R1
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> (!mem_rd_en && !done));

  // R5
  fault_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> fault != 2'b11);

  // R10
  idle_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);
endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  typedef struct packed {
    logic [15:0] sel;
    logic [31:0] off;
    logic [1:0]  cpl;
    logic [1:0]  flt;
    logic [31:0] lin;
    logic [2:0]  lat;
  } vec_t;

  // 0..1 R1/R2/R3/R5, 2 R5, 3..4 R4, 5 R8, 6..8 R2/R3, 9..10 R1/R4,
  // 11..14 R7, 15..18 R6
  localparam vec_t VECS [0:NVEC-1] = '{
    '{16'h0008, 32'h0000_0010, 2'd0, 2'd0, 32'h1234_5688, 3'd3},
    '{16'h0008, 32'h0000_0FFF, 2'd0, 2'd0, 32'h1234_6677, 3'd3},
    '{16'h0008, 32'h0000_1000, 2'd0, 2'd1, 32'h0000_0000, 3'd3},
    '{16'h0010, 32'h0000_2FFF, 2'd0, 2'd0, 32'hA000_2FFF, 3'd3},
    '{16'h0010, 32'h0000_3000, 2'd0, 2'd1, 32'h0000_0000, 3'd3},
    '{16'h0018, 32'hFFFF_FFFF, 2'd0, 2'd2, 32'h0000_0000, 3'd3},
    '{16'h0020, 32'h0000_0200, 2'd0, 2'd0, 32'h0100_0100, 3'd3},
    '{16'h0020, 32'h000F_0000, 2'd0, 2'd0, 32'h010E_FF00, 3'd3},
    '{16'h0020, 32'h000F_0001, 2'd0, 2'd1, 32'h0000_0000, 3'd3},
    '{16'h0004, 32'hFFFF_FFF0, 2'd0, 2'd0, 32'h0000_3FF0, 3'd3},
    '{16'h000C, 32'h0000_0005, 2'd0, 2'd0, 32'h7000_0005, 3'd3},
    '{16'h003C, 32'h0000_0010, 2'd0, 2'd0, 32'h5555_0010, 3'd3},
    '{16'h0044, 32'h0000_0000, 2'd0, 2'd1, 32'h0000_0000, 3'd1},
    '{16'h0078, 32'h0000_0001, 2'd0, 2'd0, 32'h0BAD_0001, 3'd3},
    '{16'h0080, 32'h0000_0000, 2'd0, 2'd1, 32'h0000_0000, 3'd1},
    '{16'h000B, 32'h0000_0010, 2'd3, 2'd0, 32'h1234_5688, 3'd3},
    '{16'h000A, 32'h0000_0010, 2'd3, 2'd1, 32'h0000_0000, 3'd1},
    '{16'h0009, 32'h0000_0010, 2'd1, 2'd0, 32'h1234_5688, 3'd3},
    '{16'h0009, 32'h0000_0010, 2'd2, 2'd1, 32'h0000_0000, 3'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic [1:0]  cur_pl = '0;
  logic [31:0] gtab_base = 32'h0000_0000;
  logic [15:0] gtab_lim  = 16'h007F;
  logic [31:0] ltab_base = 32'h0000_0100;
  logic [15:0] ltab_lim  = 16'h003F;
  logic        mem_rd_en;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata = '0;
  logic        done;
  logic [31:0] lin_addr;
  logic [1:0]  fault;

  logic [63:0] mem [0:63];
  int checks = 0;
  int fails = 0;
  int rd_cnt = 0;
  bit finished = 0;

  seg_xlate uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_off(req_off), .cur_pl(cur_pl),
    .gtab_base(gtab_base), .gtab_lim(gtab_lim),
    .ltab_base(ltab_base), .ltab_lim(ltab_lim),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .lin_addr(lin_addr), .fault(fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr[8:3]];
      rd_cnt    <= rd_cnt + 1;
    end
  end

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
                                     input logic g, input logic p);
    logic [63:0] d;
    d = '0;
    d[15:0]  = l[15:0];
    d[39:16] = b[23:0];
    d[47]    = p;
    d[44:40] = 5'b10010;
    d[51:48] = l[19:16];
    d[54]    = 1'b1;
    d[55]    = g;
    d[63:56] = b[31:24];
    return d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input string req, input bit hold_busy);
    int n;
    int rd0;
    @(negedge clk);
    rd0 = rd_cnt;
    req_valid = 1'b1;
    req_sel = v.sel;
    req_off = v.off;
    cur_pl  = v.cpl;
    @(posedge clk);
    @(negedge clk);
    chk({req, " ready low after accept"}, {31'b0, req_ready}, 32'd0);
    if (hold_busy) begin
      req_sel = 16'h0080;
      req_off = 32'hFFFF_FFFF;
      cur_pl  = 2'd3;
    end else begin
      req_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
      if (n == 1) req_valid = 1'b0;
    end
    req_valid = 1'b0;
    chk({req, " latency"}, n, {29'b0, v.lat});
    chk({req, " fault"}, {30'b0, fault}, {30'b0, v.flt});
    chk({req, " lin_addr"}, lin_addr, v.lin);
    chk({req, " reads"}, rd_cnt - rd0, (v.lat == 3'd3) ? 32'd1 : 32'd0);
    @(negedge clk);
    chk({req, " done single pulse"}, {31'b0, done}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[1]  = mk(32'h1234_5678, 20'h00FFF, 1'b0, 1'b1);
    mem[2]  = mk(32'hA000_0000, 20'h00002, 1'b1, 1'b1);
    mem[3]  = mk(32'hFF00_0000, 20'hABCDE, 1'b0, 1'b0);
    mem[4]  = mk(32'h00FF_FF00, 20'hF0000, 1'b0, 1'b1);
    mem[15] = mk(32'h0BAD_0000, 20'h000FF, 1'b0, 1'b1);
    mem[32] = mk(32'h0000_4000, 20'hFFFFF, 1'b1, 1'b1);
    mem[33] = mk(32'h7000_0000, 20'hFFFFF, 1'b0, 1'b1);
    mem[39] = mk(32'h5555_0000, 20'h00010, 1'b0, 1'b1);

    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 ready in reset", {31'b0, req_ready}, 32'd1);
    chk("R10 done in reset", {31'b0, done}, 32'd0);
    chk("R10 rd_en in reset", {31'b0, mem_rd_en}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R10 done after reset", {31'b0, done}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      if (i <= 1)       tag = "R1 R2 R3 R5";
      else if (i == 2)  tag = "R5";
      else if (i <= 4)  tag = "R4";
      else if (i == 5)  tag = "R8";
      else if (i <= 8)  tag = "R2 R3";
      else if (i <= 10) tag = "R1 R4";
      else if (i <= 14) tag = "R7";
      else              tag = "R6";
      run(VECS[i], $sformatf("%s vec%0d", tag, i), 1'b0);
    end

    // R9: inputs changed while busy are ignored
    run(VECS[0], "R9 busy ignore", 1'b1);

    // R9 R10: reset in the middle of a request aborts it
    @(negedge clk);
    req_valid = 1'b1;
    req_sel = 16'h0008;
    req_off = 32'h0;
    cur_pl = 2'd0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 ready after mid reset", {31'b0, req_ready}, 32'd1);
    repeat (4) begin
      @(negedge clk);
      chk("R10 no done after mid reset", {31'b0, done}, 32'd0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule